// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block is the identity layer of a slave on a shared single-wire open-drain bus. It sits above a bit-timing front end and below a memory-function layer. The front end reports three events to it: a detected bus reset, a bit written by the master (a strobe plus the bit value), and a read slot opened by the master. For every read slot the engine supplies the bit that the slave puts on the bus. A value of 1 means the slave leaves the line released, so the line shows the wired-AND of all slaves that answer.

After a bus reset the engine takes in an 8-bit command and runs one of four identity functions against a fixed 64-bit identity:

- **Read identity** sends the identity bits.
- **Match identity** compares a 64-bit address sent by the master with the identity.
- **Skip identity** selects the slave at once.
- **Search identity** runs the bit-by-bit elimination in which competing slaves drop out.

When a function succeeds, the engine raises `selected_o`, which hands the bus to the memory layer. When a function fails, or the command code is unknown, the slave goes silent until the next bus reset.

Top module: `swrom_engine`

## Requirements
- R1: After `rst_ni` releases, and until the first `bus_reset_i` pulse, the block ignores every bus input: `selected_o` stays 0 and `tx_bit_o` stays 1.
- R2: A command is 8 bits written by the master, least-significant bit first. The accepted codes are 0x33 (read identity), 0x55 (match identity), 0xCC (skip identity) and 0xF0 (search identity).
- R3: Under read identity, read slot k (k = 0..63) presents `ROM_ID[k]` on `tx_bit_o`, so the family code in bits 7:0 goes out first. `selected_o` rises at the clock edge that closes the 64th slot.
- R4: Under match identity, the master writes 64 bits. If bit k equals `ROM_ID[k]` for every k, `selected_o` rises at the edge of the 64th bit. Any differing bit makes the slave silent (`tx_bit_o` = 1, `selected_o` = 0) until the next bus reset.
- R5: Under skip identity, `selected_o` rises at the clock edge that takes in the 8th command bit.
- R6: Under search identity, each identity bit k takes three steps: a read slot returning `ROM_ID[k]`, a read slot returning its complement, and a master write. If the written bit differs from `ROM_ID[k]`, the slave goes silent until the next bus reset. If all 64 written bits agree, `selected_o` rises at the edge of the last write.
- R7: Any code other than the four in R2 leaves the slave silent, with `tx_bit_o` = 1 and `selected_o` = 0, until the next bus reset. Later commands written before that reset have no effect.
- R8: A `bus_reset_i` pulse in any state aborts the current function. `selected_o` reads 0 after that edge, and the next 8 written bits are decoded as a fresh command.
- R9: `tx_bit_o` is 1 at every time except the read slots of R3 and the first two steps of R6.
- R10: Once `selected_o` is 1, written bits and read slots do not change it until a bus reset. `tx_bit_o` stays 1 during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_reset_i | input | 1 | One-cycle pulse: a bus reset was seen on the line |
| rx_valid_i | input | 1 | One-cycle strobe: the master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit, qualified by `rx_valid_i` |
| tx_req_i | input | 1 | One-cycle strobe: the master opened a read slot, and `tx_bit_o` is consumed at this edge |
| tx_bit_o | output | 1 | Bit to put on the bus in the current read slot (1 = release) |
| selected_o | output | 1 | The slave is addressed and hands over to the memory layer |

## Verification
The bench places two engines on one wired-AND bus. Both use the default 64-bit identity and 8-bit command width. One is built with the indexed bit selector and the other with the shifting bit selector, so both variants answer the same slots.

The two identities share their family code and most of their serial bits. Because of this, the search walks through a long prefix where both slaves answer, before the first bit where they disagree and one drops out.

At this width the bench can sweep every one of the 64 single-bit corruptions of a match address and all 252 unused command codes. It can also compare each wired-AND read slot with a value worked out from the two identities.

// File: rtl/swrom_pkg.sv
package swrom_pkg;

   localparam int CMD_BITS = 8;

   localparam logic [CMD_BITS-1:0] OP_READ_ID   = 8'h33;
   localparam logic [CMD_BITS-1:0] OP_MATCH_ID  = 8'h55;
   localparam logic [CMD_BITS-1:0] OP_SKIP_ID   = 8'hCC;
   localparam logic [CMD_BITS-1:0] OP_SEARCH_ID = 8'hF0;

   typedef enum logic [2:0] {
      ST_NO_RESET,
      ST_COMMAND,
      ST_READ,
      ST_MATCH,
      ST_SEARCH,
      ST_SELECTED,
      ST_SILENT
   } eng_state_e;

   typedef enum logic [1:0] {
      PH_TRUE,
      PH_CMPL,
      PH_PICK
   } srch_phase_e;

endpackage

// File: rtl/swrom_cmd_rx.sv
module swrom_cmd_rx #(
   parameter int CMD_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             en_i,
   input  logic             bit_valid_i,
   input  logic             bit_i,
   output logic             done_o,
   output logic [CMD_W-1:0] byte_o
);

   localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;

   generate
      if (CMD_W < 2) begin : g_bad_width
         $error("swrom_cmd_rx: CMD_W must be at least 2");
      end
   endgenerate

   logic [CMD_W-1:0] sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take   = en_i && bit_valid_i;
   // least significant bit arrives first, so new bits enter at the top
   assign byte_o = {bit_i, sh_q[CMD_W-1:1]};
   assign done_o = take && (cnt_q == CNT_W'(CMD_W-1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= byte_o;
         cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: each accepted bit advances the bit count by exactly one
   a_r2_cmd_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take && !clear_i && !done_o |=> cnt_q == $past(cnt_q) + 1'b1);

   // R8: a bus reset restarts command reception from bit zero
   a_r8_cmd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> cnt_q == '0);

endmodule

// File: rtl/swrom_id_seq.sv
module swrom_id_seq #(
   parameter int                   ID_BITS = 64,
   parameter logic [ID_BITS-1:0]   ROM_ID  = '0,
   parameter bit                   SHIFT_SEL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic step_i,
   output logic bit_o,
   output logic last_o
);

   localparam int IDX_W = $clog2(ID_BITS);

   generate
      if (ID_BITS < 16 || (ID_BITS % 8) != 0) begin : g_bad_id
         $error("swrom_id_seq: ID_BITS must be a multiple of 8, at least 16");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;

   assign last_o = (idx_q == IDX_W'(ID_BITS-1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         idx_q <= '0;
      end else if (clear_i) begin
         idx_q <= '0;
      end else if (step_i) begin
         idx_q <= last_o ? '0 : idx_q + 1'b1;
      end
   end

   generate
      if (SHIFT_SEL) begin : g_shift
         logic [ID_BITS-1:0] sr_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               sr_q <= ROM_ID;
            end else if (clear_i || (step_i && last_o)) begin
               sr_q <= ROM_ID;
            end else if (step_i) begin
               sr_q <= {1'b0, sr_q[ID_BITS-1:1]};
            end
         end
         assign bit_o = sr_q[0];
      end else begin : g_index
         assign bit_o = ROM_ID[idx_q];
      end
   endgenerate

   // R3: after a restart the first identity bit offered is bit zero
   a_r3_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> bit_o == ROM_ID[0]);

   // R3: the index wraps to zero after the final identity bit
   a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i && last_o && !clear_i |=> idx_q == '0);

endmodule

// File: rtl/swrom_engine.sv
module swrom_engine
   import swrom_pkg::*;
#(
   parameter int                 ID_BITS  = 64,
   parameter logic [ID_BITS-1:0] ROM_ID   = 64'h5E3A9C0F17B2642D,
   parameter int                 CMD_W    = 8,
   parameter bit                 ID_SHIFT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bus_reset_i,
   input  logic rx_valid_i,
   input  logic rx_bit_i,
   input  logic tx_req_i,
   output logic tx_bit_o,
   output logic selected_o
);

   generate
      if (CMD_W != CMD_BITS) begin : g_bad_cmd
         $error("swrom_engine: CMD_W must equal the command code width");
      end
   endgenerate

   eng_state_e  state_q, state_d;
   srch_phase_e phase_q, phase_d;

   logic             cmd_done;
   logic [CMD_W-1:0] cmd_byte;
   logic             id_bit;
   logic             id_last;
   logic             id_step;
   logic             pick_ok;

   swrom_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (bus_reset_i),
      .en_i       (state_q == ST_COMMAND),
      .bit_valid_i(rx_valid_i),
      .bit_i      (rx_bit_i),
      .done_o     (cmd_done),
      .byte_o     (cmd_byte)
   );

   swrom_id_seq #(
      .ID_BITS  (ID_BITS),
      .ROM_ID   (ROM_ID),
      .SHIFT_SEL(ID_SHIFT)
   ) u_id (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(bus_reset_i),
      .step_i (id_step),
      .bit_o  (id_bit),
      .last_o (id_last)
   );

   assign pick_ok = (rx_bit_i == id_bit);

   always_comb begin
      id_step = 1'b0;
      unique case (state_q)
         ST_READ:   id_step = tx_req_i;
         ST_MATCH:  id_step = rx_valid_i && pick_ok;
         ST_SEARCH: id_step = (phase_q == PH_PICK) && rx_valid_i && pick_ok;
         default:   id_step = 1'b0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      if (bus_reset_i) begin
         state_d = ST_COMMAND;
         phase_d = PH_TRUE;
      end else begin
         unique case (state_q)
            ST_COMMAND: begin
               if (cmd_done) begin
                  phase_d = PH_TRUE;
                  unique case (cmd_byte)
                     OP_READ_ID:   state_d = ST_READ;
                     OP_MATCH_ID:  state_d = ST_MATCH;
                     OP_SKIP_ID:   state_d = ST_SELECTED;
                     OP_SEARCH_ID: state_d = ST_SEARCH;
                     default:      state_d = ST_SILENT;
                  endcase
               end
            end
            ST_READ: begin
               if (tx_req_i && id_last) state_d = ST_SELECTED;
            end
            ST_MATCH: begin
               if (rx_valid_i) begin
                  if (!pick_ok)     state_d = ST_SILENT;
                  else if (id_last) state_d = ST_SELECTED;
               end
            end
            ST_SEARCH: begin
               unique case (phase_q)
                  PH_TRUE: if (tx_req_i) phase_d = PH_CMPL;
                  PH_CMPL: if (tx_req_i) phase_d = PH_PICK;
                  default: begin
                     if (rx_valid_i) begin
                        phase_d = PH_TRUE;
                        if (!pick_ok)     state_d = ST_SILENT;
                        else if (id_last) state_d = ST_SELECTED;
                     end
                  end
               endcase
            end
            default: begin
               state_d = state_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_NO_RESET;
         phase_q <= PH_TRUE;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
      end
   end

   always_comb begin
      tx_bit_o = 1'b1;
      if (state_q == ST_READ) begin
         tx_bit_o = id_bit;
      end else if (state_q == ST_SEARCH) begin
         if (phase_q == PH_TRUE)      tx_bit_o = id_bit;
         else if (phase_q == PH_CMPL) tx_bit_o = ~id_bit;
      end
   end

   assign selected_o = (state_q == ST_SELECTED);

   // R1: before any bus reset the engine stays in its waiting state
   a_r1_wait_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_NO_RESET && !bus_reset_i |=> state_q == ST_NO_RESET);

   // R5: the skip code selects at the edge that takes in its last bit
   a_r5_skip_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_COMMAND && cmd_done && cmd_byte == OP_SKIP_ID && !bus_reset_i
      |=> selected_o);

   // R6: a disagreeing written bit during search silences the slave
   a_r6_search_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_SEARCH && phase_q == PH_PICK && rx_valid_i && !pick_ok && !bus_reset_i
      |=> state_q == ST_SILENT);

   // R4: a disagreeing address bit silences the slave
   a_r4_match_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_MATCH && rx_valid_i && !pick_ok && !bus_reset_i
      |=> !selected_o && tx_bit_o);

   // R7: silence persists until a bus reset
   a_r7_silent_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_SILENT && !bus_reset_i |=> state_q == ST_SILENT && tx_bit_o);

   // R8: a bus reset always drops the selection
   a_r8_reset_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_reset_i |=> !selected_o);

   // R10: selection holds until a bus reset
   a_r10_sel_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      selected_o && !bus_reset_i |=> selected_o && tx_bit_o);

endmodule

// File: tb/swrom_engine_tb.sv
module swrom_engine_tb;

   localparam logic [63:0] ID_A = 64'h5E3A9C0F17B2642D;
   localparam logic [63:0] ID_B = 64'h913A9C0E17B2A42D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0;
   logic rx_valid = 1'b0;
   logic rx_bit = 1'b0;
   logic tx_req = 1'b0;
   logic tx_a, tx_b, sel_a, sel_b, bus;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign bus = tx_a & tx_b;

   swrom_engine #(.ID_BITS(64), .ROM_ID(ID_A), .CMD_W(8), .ID_SHIFT(1'b0)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .rx_valid_i(rx_valid),
      .rx_bit_i(rx_bit), .tx_req_i(tx_req), .tx_bit_o(tx_a), .selected_o(sel_a)
   );

   swrom_engine #(.ID_BITS(64), .ROM_ID(ID_B), .CMD_W(8), .ID_SHIFT(1'b1)) u_dut_b (
      .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .rx_valid_i(rx_valid),
      .rx_bit_i(rx_bit), .tx_req_i(tx_req), .tx_bit_o(tx_b), .selected_o(sel_b)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_rst();
      @(negedge clk) bus_reset = 1'b1;
      @(negedge clk) bus_reset = 1'b0;
   endtask

   task automatic wr_bit(input logic b);
      @(negedge clk) begin rx_valid = 1'b1; rx_bit = b; end
      @(negedge clk) rx_valid = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wr_bit(v[i]);
   endtask

   task automatic rd_bit(output logic b);
      @(negedge clk) begin tx_req = 1'b1; b = bus; end
      @(negedge clk) tx_req = 1'b0;
   endtask

   task automatic do_search(input logic [63:0] target, input logic want_a);
      logic alive_a, alive_b, b1, b2, e1, e2;
      alive_a = 1'b1;
      alive_b = 1'b1;
      for (int i = 0; i < 64; i++) begin
         e1 = (alive_a ? ID_A[i] : 1'b1) & (alive_b ? ID_B[i] : 1'b1);
         e2 = (alive_a ? ~ID_A[i] : 1'b1) & (alive_b ? ~ID_B[i] : 1'b1);
         rd_bit(b1);
         check("R6 search true bit", {63'd0, b1}, {63'd0, e1});
         rd_bit(b2);
         check("R6 search complement", {63'd0, b2}, {63'd0, e2});
         wr_bit(target[i]);
         alive_a = alive_a & (ID_A[i] == target[i]);
         alive_b = alive_b & (ID_B[i] == target[i]);
      end
      check("R6 search selects A", {63'd0, sel_a}, {63'd0, want_a});
      check("R6 search selects B", {63'd0, sel_b}, {63'd0, !want_a});
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic b;
      logic [63:0] addr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet before any bus reset
      check("R1 sel after reset", {62'd0, sel_a, sel_b}, 64'd0);
      rd_bit(b);
      check("R1 released before bus reset", {63'd0, b}, 64'd1);
      wr_byte(8'hCC);
      check("R1 command ignored", {62'd0, sel_a, sel_b}, 64'd0);

      // R5 skip, R10 hold, R9 release
      bus_rst();
      rd_bit(b);
      check("R9 release while awaiting command", {63'd0, b}, 64'd1);
      wr_byte(8'hCC);
      check("R5 skip selects both", {62'd0, sel_a, sel_b}, 64'd3);
      wr_bit(1'b0);
      wr_bit(1'b1);
      rd_bit(b);
      check("R10 release while selected", {63'd0, b}, 64'd1);
      check("R10 selection held", {62'd0, sel_a, sel_b}, 64'd3);

      // R2 bit order: 0x33 written MSB-first is 0xCC LSB-first
      bus_rst();
      for (int i = 7; i >= 0; i--) wr_bit(logic'(8'h33 >> i));
      check("R2 reversed order decodes as skip", {62'd0, sel_a, sel_b}, 64'd3);

      // R3 read identity with wired-AND
      bus_rst();
      wr_byte(8'h33);
      for (int i = 0; i < 64; i++) begin
         rd_bit(b);
         check("R3 read slot", {63'd0, b}, {63'd0, ID_A[i] & ID_B[i]});
         if (i == 62) check("R3 not selected before last slot", {62'd0, sel_a, sel_b}, 64'd0);
      end
      check("R3 selected after 64 slots", {62'd0, sel_a, sel_b}, 64'd3);

      // R8 abort mid-read
      bus_rst();
      wr_byte(8'h33);
      for (int i = 0; i < 10; i++) rd_bit(b);
      bus_rst();
      check("R8 abort clears selection", {62'd0, sel_a, sel_b}, 64'd0);
      rd_bit(b);
      check("R8 read aborted", {63'd0, b}, 64'd1);
      wr_byte(8'hCC);
      check("R8 fresh command decoded", {62'd0, sel_a, sel_b}, 64'd3);
      bus_rst();
      check("R8 reset drops selection", {62'd0, sel_a, sel_b}, 64'd0);

      // R4 match A
      wr_byte(8'h55);
      for (int i = 0; i < 64; i++) wr_bit(ID_A[i]);
      check("R4 match selects A only", {62'd0, sel_a, sel_b}, 64'd2);
      check("R4 mismatched slave silent", {63'd0, tx_b}, 64'd1);

      // R4 every single-bit corruption
      for (int k = 0; k < 64; k++) begin
         addr = ID_A ^ (64'd1 << k);
         bus_rst();
         wr_byte(8'h55);
         for (int i = 0; i < 64; i++) wr_bit(addr[i]);
         check("R4 corrupted address", {62'd0, sel_a, sel_b}, 64'd0);
         check("R4 silent after mismatch", {62'd0, tx_a, tx_b}, 64'd3);
      end

      // R7 every unused code
      for (int c = 0; c < 256; c++) begin
         if (c != 8'h33 && c != 8'h55 && c != 8'hCC && c != 8'hF0) begin
            bus_rst();
            wr_byte(8'(c));
            rd_bit(b);
            check("R7 unknown code silent", {63'd0, b}, 64'd1);
            wr_byte(8'hCC);
            check("R7 later command ignored", {62'd0, sel_a, sel_b}, 64'd0);
         end
      end

      // R6 search isolates each slave
      bus_rst();
      wr_byte(8'hF0);
      do_search(ID_A, 1'b1);
      bus_rst();
      wr_byte(8'hF0);
      do_search(ID_B, 1'b0);
      rd_bit(b);
      check("R9 release after search", {63'd0, b}, 64'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule